// File: doc/BRIEF.md
# Guarded Control Register with Unlock Sequence

This block holds a one-byte control and status register for a small mixed-signal device. The register sits behind a byte-level serial transaction interface. Each transaction opens with a start pulse, carries bytes qualified by a valid strobe, and closes with a stop pulse. The block answers each byte it accepts with an acknowledge one cycle later.

Two volatile latches guard changes to the persistent bits of the register: a general write enable and a register write enable. A fixed three-write sequence must set them in turn before the third write commits the persistent bits. The commit then holds a busy flag for a parameterised number of cycles, standing in for the long storage write time.

A write-protect input pin and a lock bit stored in the register together decide two permission outputs. These tell the rest of the device whether volatile or persistent writes to its downstream settings may proceed. The register can be read back at any time, including while a commit is still running.

Top module: `ctlreg_guard`

## Requirements
- R1: The readback byte is, from bit 7 to bit 0: delay-select high, monitor status A, monitor status B, a constant 0, lock, register write enable, general write enable, delay-select low. Bit 4 always reads 0, whatever value was written there.
- R2: A write transaction of 02h sets the general write enable. A later write of 06h sets the register write enable, but only while the general write enable is already set.
- R3: With the register write enable set and bit 2 of the written byte at 0, the write loads bits 7, 6, 5, 3 and 0 into the persistent bits. It also clears the register write enable and starts the busy flag. The general write enable keeps its value.
- R4: With the register write enable set and bit 2 of the written byte at 1, the persistent bits stay unchanged and the register write enable stays set.
- R5: The busy flag is high for exactly BUSY_CYCLES cycles after a commit. Register writes that complete while busy is high have no effect.
- R6: A write transaction is: address A4h, register address FFh, then exactly one data byte. A second data byte is not acknowledged, and the whole write is dropped at stop.
- R7: While the write-protect pin is high, register writes have no effect and both permission outputs are low.
- R8: vol_wr_ok is high exactly when the general write enable is set and the protect pin is low. nv_wr_ok additionally requires the lock bit to be clear.
- R9: A read transaction is address A5h followed by FFh. rd_vld pulses with the register byte in the cycle after the FFh byte. Any further byte in that transaction is not acknowledged. A read during busy returns the current value and leaves the commit running.
- R10: A byte is acknowledged, one cycle after its valid strobe, only when it is a legal next byte of the transaction. A first byte other than A4h/A5h, or a second byte other than FFh, is refused, and the rest of that transaction is ignored.
- R11: Reset clears both enable latches and busy and loads the persistent bits from NV_INIT. A write of any value other than 02h, or 06h with the general write enable set, leaves the register unchanged while the register write enable is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| txn_start | input | 1 | Start of a transaction (one-cycle pulse) |
| txn_stop | input | 1 | End of a transaction (one-cycle pulse) |
| byte_vld | input | 1 | A byte is present on byte_in |
| byte_in | input | 8 | Received byte |
| wp_pin | input | 1 | Write-protect pin, active high |
| ack | output | 1 | Acknowledge for the byte of the previous cycle |
| rd_vld | output | 1 | Read data valid, one cycle |
| rd_data | output | 8 | Register readback byte |
| busy | output | 1 | Persistent commit in progress |
| vol_wr_ok | output | 1 | Volatile downstream writes permitted |
| nv_wr_ok | output | 1 | Persistent downstream writes permitted |

## Verification
The assertions take it for granted that start, byte-valid and stop never coincide in one cycle, and that every read transaction carries at least two bytes. Under those conditions, two read pulses can never come on consecutive cycles. The stimulus drives each of those signals in a cycle of its own and always separates transactions with idle cycles. The protect pin changes only between transactions. The busy-length check assumes BUSY_CYCLES of at least 2, which the bench keeps by overriding it to 20.

// File: rtl/ctlreg_pkg.sv
package ctlreg_pkg;

    localparam logic [7:0] DEV_WR_ADDR = 8'hA4;
    localparam logic [7:0] DEV_RD_ADDR = 8'hA5;
    localparam logic [7:0] REG_ADDR    = 8'hFF;
    localparam logic [7:0] CMD_WEL     = 8'h02;
    localparam logic [7:0] CMD_RWEL    = 8'h06;
    localparam int         BIT_RWEL    = 2;

    typedef struct packed {
        logic dly_hi;
        logic mon_a;
        logic mon_b;
        logic lock;
        logic dly_lo;
    } nv_t;

    function automatic nv_t nv_from_byte(input logic [7:0] b);
        nv_t n;
        n.dly_hi = b[7];
        n.mon_a  = b[6];
        n.mon_b  = b[5];
        n.lock   = b[3];
        n.dly_lo = b[0];
        return n;
    endfunction

    function automatic logic [7:0] view_byte(input nv_t n, input logic rwel, input logic wel);
        return {n.dly_hi, n.mon_a, n.mon_b, 1'b0, n.lock, rwel, wel, n.dly_lo};
    endfunction

endpackage

// File: rtl/ctlreg_xact.sv
module ctlreg_xact
    import ctlreg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       txn_start,
    input  logic       txn_stop,
    input  logic       byte_vld,
    input  logic [7:0] byte_in,
    input  logic [7:0] reg_view,
    output logic       ack,
    output logic       rd_vld,
    output logic [7:0] rd_data,
    output logic       wr_go,
    output logic [7:0] wr_byte
);

    typedef struct packed {
        logic       active;
        logic       ign;
        logic       is_rd;
        logic [1:0] idx;
        logic       have;
        logic       abort;
        logic [7:0] dat;
        logic       ack;
        logic       rd_vld;
        logic [7:0] rd_data;
        logic       wr_go;
    } xs_t;

    xs_t xs_d, xs_q;

    always_comb begin
        xs_d        = xs_q;
        xs_d.ack    = 1'b0;
        xs_d.rd_vld = 1'b0;
        xs_d.wr_go  = 1'b0;
        if (txn_start) begin
            xs_d.active = 1'b1;
            xs_d.ign    = 1'b0;
            xs_d.is_rd  = 1'b0;
            xs_d.idx    = 2'd0;
            xs_d.have   = 1'b0;
            xs_d.abort  = 1'b0;
        end else if (txn_stop) begin
            if (xs_q.active && !xs_q.ign && !xs_q.is_rd && xs_q.have && !xs_q.abort) begin
                xs_d.wr_go = 1'b1;
            end
            xs_d.active = 1'b0;
        end else if (byte_vld && xs_q.active && !xs_q.ign) begin
            if (xs_q.idx != 2'd3) begin
                xs_d.idx = xs_q.idx + 2'd1;
            end
            case (xs_q.idx)
                2'd0: begin
                    if (byte_in == DEV_WR_ADDR) begin
                        xs_d.ack   = 1'b1;
                        xs_d.is_rd = 1'b0;
                    end else if (byte_in == DEV_RD_ADDR) begin
                        xs_d.ack   = 1'b1;
                        xs_d.is_rd = 1'b1;
                    end else begin
                        xs_d.ign = 1'b1;
                    end
                end
                2'd1: begin
                    if (byte_in == REG_ADDR) begin
                        xs_d.ack = 1'b1;
                        if (xs_q.is_rd) begin
                            xs_d.rd_vld  = 1'b1;
                            xs_d.rd_data = reg_view;
                        end
                    end else begin
                        xs_d.ign = 1'b1;
                    end
                end
                default: begin
                    if (xs_q.is_rd) begin
                        xs_d.ign = 1'b1;
                    end else if (!xs_q.have) begin
                        xs_d.have = 1'b1;
                        xs_d.dat  = byte_in;
                        xs_d.ack  = 1'b1;
                    end else begin
                        xs_d.abort = 1'b1;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            xs_q <= '0;
        end else begin
            xs_q <= xs_d;
        end
    end

    assign ack     = xs_q.ack;
    assign rd_vld  = xs_q.rd_vld;
    assign rd_data = xs_q.rd_data;
    assign wr_go   = xs_q.wr_go;
    assign wr_byte = xs_q.dat;

endmodule

// File: rtl/ctlreg_unlock.sv
module ctlreg_unlock
    import ctlreg_pkg::*;
#(
    parameter logic [7:0] NV_INIT = 8'h41
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_go,
    input  logic [7:0] wr_byte,
    input  logic       wp_pin,
    input  logic       busy,
    output logic [7:0] reg_view,
    output logic       commit,
    output logic       wel,
    output logic       rwel,
    output logic       lock
);

    typedef struct packed {
        nv_t  nv;
        logic wel;
        logic rwel;
    } us_t;

    us_t us_d, us_q;
    logic commit_d;

    always_comb begin
        us_d     = us_q;
        commit_d = 1'b0;
        if (wr_go && !wp_pin && !busy) begin
            if (us_q.rwel) begin
                if (!wr_byte[BIT_RWEL]) begin
                    us_d.nv   = nv_from_byte(wr_byte);
                    us_d.rwel = 1'b0;
                    commit_d  = 1'b1;
                end
            end else if (wr_byte == CMD_WEL) begin
                us_d.wel = 1'b1;
            end else if (wr_byte == CMD_RWEL && us_q.wel) begin
                us_d.rwel = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            us_q.nv   <= nv_from_byte(NV_INIT);
            us_q.wel  <= 1'b0;
            us_q.rwel <= 1'b0;
        end else begin
            us_q <= us_d;
        end
    end

    assign reg_view = view_byte(us_q.nv, us_q.rwel, us_q.wel);
    assign commit   = commit_d;
    assign wel      = us_q.wel;
    assign rwel     = us_q.rwel;
    assign lock     = us_q.nv.lock;

endmodule

// File: rtl/ctlreg_busy.sv
module ctlreg_busy #(
    parameter int BUSY_CYCLES = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic commit,
    output logic busy
);

    localparam int CW = $clog2(BUSY_CYCLES + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } bs_t;

    bs_t bs_d, bs_q;

    always_comb begin
        bs_d = bs_q;
        if (commit) begin
            bs_d.cnt = CW'(BUSY_CYCLES);
        end else if (bs_q.cnt != '0) begin
            bs_d.cnt = bs_q.cnt - CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bs_q <= '0;
        end else begin
            bs_q <= bs_d;
        end
    end

    assign busy = (bs_q.cnt != '0);

endmodule

// File: rtl/ctlreg_guard.sv
module ctlreg_guard
    import ctlreg_pkg::*;
#(
    parameter int         BUSY_CYCLES = 5000,
    parameter logic [7:0] NV_INIT     = 8'h41
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       txn_start,
    input  logic       txn_stop,
    input  logic       byte_vld,
    input  logic [7:0] byte_in,
    input  logic       wp_pin,
    output logic       ack,
    output logic       rd_vld,
    output logic [7:0] rd_data,
    output logic       busy,
    output logic       vol_wr_ok,
    output logic       nv_wr_ok
);

    logic [7:0] reg_view_w;
    logic       wr_go_w;
    logic [7:0] wr_byte_w;
    logic       commit_w;
    logic       wel_w;
    logic       rwel_w;
    logic       lock_w;
    logic       busy_w;

    ctlreg_xact u_xact (
        .clk      (clk),
        .rst_n    (rst_n),
        .txn_start(txn_start),
        .txn_stop (txn_stop),
        .byte_vld (byte_vld),
        .byte_in  (byte_in),
        .reg_view (reg_view_w),
        .ack      (ack),
        .rd_vld   (rd_vld),
        .rd_data  (rd_data),
        .wr_go    (wr_go_w),
        .wr_byte  (wr_byte_w)
    );

    ctlreg_unlock #(.NV_INIT(NV_INIT)) u_unlock (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_go   (wr_go_w),
        .wr_byte (wr_byte_w),
        .wp_pin  (wp_pin),
        .busy    (busy_w),
        .reg_view(reg_view_w),
        .commit  (commit_w),
        .wel     (wel_w),
        .rwel    (rwel_w),
        .lock    (lock_w)
    );

    ctlreg_busy #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
        .clk   (clk),
        .rst_n (rst_n),
        .commit(commit_w),
        .busy  (busy_w)
    );

    assign busy      = busy_w;
    assign vol_wr_ok = wel_w && !wp_pin;
    assign nv_wr_ok  = wel_w && !wp_pin && !lock_w;

endmodule

// File: rtl/ctlreg_guard_chk.sv
module ctlreg_guard_chk #(
    parameter int BUSY_CYCLES = 5000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       wp_pin,
    input logic       byte_vld,
    input logic       ack,
    input logic       rd_vld,
    input logic [7:0] rd_data,
    input logic       busy,
    input logic       vol_wr_ok,
    input logic       nv_wr_ok,
    input logic       rwel
);

    logic [31:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (busy) begin
            run_q <= run_q + 32'd1;
        end else begin
            run_q <= '0;
        end
    end

    a_r8_vol_needs_unprotected: assert property (@(posedge clk) disable iff (!rst_n)
        vol_wr_ok |-> !wp_pin);

    a_r8_nv_implies_vol: assert property (@(posedge clk) disable iff (!rst_n)
        nv_wr_ok |-> vol_wr_ok);

    a_r5_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_q == 32'(BUSY_CYCLES)));

    a_r3_commit_clears_rwel: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !rwel);

    a_r1_bit4_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_vld |-> (rd_data[4] == 1'b0));

    a_r9_single_byte: assert property (@(posedge clk) disable iff (!rst_n)
        rd_vld |=> !rd_vld);

    a_r10_ack_follows_byte: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> $past(byte_vld));

endmodule

bind ctlreg_guard ctlreg_guard_chk #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wp_pin   (wp_pin),
    .byte_vld (byte_vld),
    .ack      (ack),
    .rd_vld   (rd_vld),
    .rd_data  (rd_data),
    .busy     (busy),
    .vol_wr_ok(vol_wr_ok),
    .nv_wr_ok (nv_wr_ok),
    .rwel     (rwel_w)
);

// File: tb/tb_ctlreg_guard.sv
module tb_ctlreg_guard;

    localparam int CLK_PERIOD = 10;
    localparam int BUSY_N     = 20;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       txn_start, txn_stop, byte_vld, wp_pin;
    logic [7:0] byte_in;
    logic       ack, rd_vld, busy, vol_wr_ok, nv_wr_ok;
    logic [7:0] rd_data;

    int checks = 0;
    int errors = 0;
    int run = 0;
    int last_run = 0;
    logic [7:0] exp_q[$];
    string      req_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    ctlreg_guard #(.BUSY_CYCLES(BUSY_N), .NV_INIT(8'h41)) dut (
        .clk(clk), .rst_n(rst_n), .txn_start(txn_start), .txn_stop(txn_stop),
        .byte_vld(byte_vld), .byte_in(byte_in), .wp_pin(wp_pin),
        .ack(ack), .rd_vld(rd_vld), .rd_data(rd_data), .busy(busy),
        .vol_wr_ok(vol_wr_ok), .nv_wr_ok(nv_wr_ok)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: pops expected readback values
    always @(negedge clk) begin
        if (rst_n && rd_vld) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R9 unexpected read", int'(rd_data), 0);
            end else begin
                logic [7:0] e;
                string r;
                e = exp_q.pop_front();
                r = req_q.pop_front();
                check(rd_data == e, r, int'(rd_data), int'(e));
            end
        end
    end

    // busy run-length monitor
    always @(negedge clk) begin
        if (busy) begin
            run = run + 1;
        end else begin
            if (run != 0) last_run = run;
            run = 0;
        end
    end

    task automatic t_start();
        txn_start = 1'b1; @(negedge clk); txn_start = 1'b0;
    endtask

    task automatic t_stop();
        txn_stop = 1'b1; @(negedge clk); txn_stop = 1'b0;
        @(negedge clk); @(negedge clk);
    endtask

    task automatic send(input logic [7:0] b, input bit exp_ack, input string req);
        byte_vld = 1'b1; byte_in = b;
        @(negedge clk);
        byte_vld = 1'b0;
        check(ack == exp_ack, req, int'(ack), int'(exp_ack));
    endtask

    task automatic wr(input logic [7:0] d);
        t_start();
        send(8'hA4, 1'b1, "R10 write addr ack");
        send(8'hFF, 1'b1, "R10 reg addr ack");
        send(d, 1'b1, "R6 data ack");
        t_stop();
    endtask

    task automatic rd(input logic [7:0] e, input string req);
        exp_q.push_back(e);
        req_q.push_back(req);
        t_start();
        send(8'hA5, 1'b1, "R10 read addr ack");
        send(8'hFF, 1'b1, "R9 read reg ack");
        t_stop();
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 200 && busy; i++) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic finish_run();
        check(exp_q.size() == 0, "R9 all reads returned", exp_q.size(), 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog R5 actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        txn_start = 0; txn_stop = 0; byte_vld = 0; byte_in = 0; wp_pin = 0;
        do_reset();

        // R11 reset state
        check(busy == 0, "R11 busy after reset", busy, 0);
        check(vol_wr_ok == 0 && nv_wr_ok == 0, "R11 perms after reset", {vol_wr_ok, nv_wr_ok}, 0);
        rd(8'h41, "R11 reset readback");

        // R11 out-of-sequence values; R2 06 without enable
        wr(8'h55);
        rd(8'h41, "R11 stray write ignored");
        wr(8'h06);
        rd(8'h41, "R2 06 needs enable first");

        // R2 unlock steps, R8 perms
        wr(8'h02);
        rd(8'h43, "R2 enable latch set");
        check(vol_wr_ok == 1 && nv_wr_ok == 1, "R8 perms unlocked", {vol_wr_ok, nv_wr_ok}, 3);
        wr(8'h06);
        rd(8'h47, "R2 register enable set");

        // R4 third write with bit 2 set
        wr(8'h1C);
        rd(8'h47, "R4 bit2 keeps bits");
        check(busy == 0, "R4 no commit", busy, 0);

        // R6 second data byte aborts
        t_start();
        send(8'hA4, 1'b1, "R6 addr");
        send(8'hFF, 1'b1, "R6 reg");
        send(8'h98, 1'b1, "R6 first data ack");
        send(8'h00, 1'b0, "R6 second data no ack");
        t_stop();
        rd(8'h47, "R6 aborted write no change");
        check(busy == 0, "R6 no commit", busy, 0);

        // R3 commit, R9 read during busy, R5 write during busy
        wr(8'h98);
        check(busy == 1, "R3 busy started", busy, 1);
        rd(8'h8A, "R3 R1 commit value bit4 zero");
        check(busy == 1, "R9 read leaves commit running", busy, 1);
        wr(8'h06);
        check(busy == 1, "R5 still busy", busy, 1);
        wait_idle();
        check(last_run == BUSY_N, "R5 busy length", last_run, BUSY_N);
        rd(8'h8A, "R5 write during busy ignored");
        check(vol_wr_ok == 1 && nv_wr_ok == 0, "R8 lock blocks persistent", {vol_wr_ok, nv_wr_ok}, 2);

        // R7 protect pin
        wp_pin = 1'b1;
        @(negedge clk);
        check(vol_wr_ok == 0 && nv_wr_ok == 0, "R7 perms low under protect", {vol_wr_ok, nv_wr_ok}, 0);
        wr(8'h06);
        rd(8'h8A, "R7 enable write refused");
        wp_pin = 1'b0;

        wr(8'h06);
        rd(8'h8E, "R2 register enable again");
        wp_pin = 1'b1;
        wr(8'h00);
        check(busy == 0, "R7 commit refused", busy, 0);
        rd(8'h8E, "R7 persistent write refused");
        wp_pin = 1'b0;
        wr(8'h41);
        rd(8'h43, "R3 second commit");
        wait_idle();
        check(vol_wr_ok == 1 && nv_wr_ok == 1, "R8 lock cleared", {vol_wr_ok, nv_wr_ok}, 3);

        // R10 illegal addresses
        t_start();
        send(8'h50, 1'b0, "R10 bad device addr");
        send(8'hFF, 1'b0, "R10 rest ignored");
        t_stop();
        t_start();
        send(8'hA4, 1'b1, "R10 addr");
        send(8'h10, 1'b0, "R10 bad reg addr");
        send(8'h02, 1'b0, "R10 data ignored");
        t_stop();
        rd(8'h43, "R10 no change");

        // R9 extra read byte
        exp_q.push_back(8'h43);
        req_q.push_back("R9 read value");
        t_start();
        send(8'hA5, 1'b1, "R9 addr");
        send(8'hFF, 1'b1, "R9 reg");
        send(8'h00, 1'b0, "R9 extra byte no ack");
        t_stop();

        // R11 reset again
        wr(8'h06);
        do_reset();
        check(busy == 0 && vol_wr_ok == 0, "R11 reset clears", {busy, vol_wr_ok}, 0);
        rd(8'h41, "R11 reset reload");

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule